// File: doc/BRIEF.md
# Boot-Mode-Aware Reset Sequencer

This block sequences reset for a small controller system. Reset starts asynchronously whenever the reset pin and the mode-qualifier pin are both low, and no clock is needed for this. During reset the block drives its reset output low, aborts bus cycles, cancels pending hold requests, puts the buses and I/O drivers into high impedance and enables the pull-ups on the configuration port. Release is not asynchronous. The reset pin condition passes through a two-flop synchroniser and then an N-cycle filter, and only then is the release recognised. On the release edge the block captures the boot-source select.

The sequencer has four states. `ST_RESET` holds everything in reset. `ST_WAIT_FLASH` is used for an internal-flash boot: core reset stays asserted until the flash reports that initialisation is done, or until a timeout expires. `ST_WAIT_CYCLES` is used for an external-memory boot: core reset stays asserted for a programmable 3 to 8 cycles. `ST_RUN` releases the core.

The transitions are:
- RESET to WAIT_FLASH, taken on release with the boot select high.
- RESET to WAIT_CYCLES, taken on release with the boot select low.
- WAIT_FLASH to RUN, taken on done or on timeout.
- WAIT_CYCLES to RUN, taken when the count completes.
- Any state back to RESET, taken asynchronously on reset entry.

While the core runs and the flash is still initialising, the block answers flash reads with a placeholder word that depends on the initialisation phase. A fetch of the late-phase placeholder raises an illegal-opcode trap flag.

Top module: `rst_sequencer`

## Requirements
- R1: A reset request is `rst_pin_n`=0 together with `mode_qual_n`=0. It drives `rst_out_n` low at once, without waiting for a clock edge, from any state. `rst_pin_n`=0 with `mode_qual_n`=1 has no effect on any output.
- R2: In ST_RESET the outputs are `rst_out_n`=0, `core_rst`=1, `bus_tristate`=1, `bus_abort`=1, `hold_cancel`=1 and `port_pullup`=1. In every other state `rst_out_n`=1 and the last four of these are 0.
- R3: ST_RESET is left on exactly the (FILT_CYCLES+3)-th rising clock edge after the reset request ends. A new request during that interval restarts the count.
- R4: `boot_int` is captured on the edge that leaves ST_RESET. A value of 1 selects ST_WAIT_FLASH and a value of 0 selects ST_WAIT_CYCLES. Later changes of `boot_int` have no effect until the next reset.
- R5: In ST_WAIT_FLASH, the edge that samples `flash_done`=1 moves the FSM to ST_RUN, and on that edge `core_rst` goes to 0.
- R6: If ST_WAIT_FLASH lasts FLASH_TIMEOUT cycles without `flash_done`, the FSM enters ST_RUN and `flash_timeout` goes to 1. The flag stays at 1 until the next reset request clears it. If `flash_done`=1 arrives in the last cycle of the window, the flag stays at 0.
- R7: ST_WAIT_CYCLES lasts 3+min(`ext_delay`,5) cycles, which gives 3 cycles for a value of 0 and 8 cycles for a value of 5 to 7.
- R8: A read (`rd_req`=1) sampled in ST_RUN with `flash_done`=0 gives `ph_valid`=1 one cycle later. `ph_data` is 16'hFFFF when `flash_phase2`=0 and 16'h009B when `flash_phase2`=1. In every other case `ph_valid`=0 and `ph_data`=0.
- R9: `illegal_trap` is 1 for one cycle, aligned with `ph_valid`, when the read that produced the 16'h009B placeholder was a fetch (`rd_fetch`=1).
- R10: A reset request returns the FSM to ST_RESET from ST_WAIT_FLASH, ST_WAIT_CYCLES and ST_RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_pin_n | input | 1 | Reset pin, active low |
| mode_qual_n | input | 1 | Reset-mode qualifier, active low |
| boot_int | input | 1 | Boot source select: 1 = internal flash, 0 = external memory |
| ext_delay | input | 3 | Extra release delay for an external boot |
| flash_done | input | 1 | Flash initialisation complete |
| flash_phase2 | input | 1 | Flash is in its later initialisation phase |
| rd_req | input | 1 | Flash read strobe |
| rd_fetch | input | 1 | The read is an instruction fetch |
| rst_out_n | output | 1 | Reset output, active low |
| core_rst | output | 1 | Internal core reset |
| bus_tristate | output | 1 | High-impedance enable for buses and I/O drivers |
| bus_abort | output | 1 | Abort the bus cycle in progress |
| hold_cancel | output | 1 | Cancel pending hold requests |
| port_pullup | output | 1 | Configuration port pull-up enable |
| flash_timeout | output | 1 | Sticky flag: the flash wait timed out |
| ph_valid | output | 1 | Placeholder read data valid |
| ph_data | output | 16 | Placeholder read data |
| illegal_trap | output | 1 | Illegal-opcode trap flag |

## Verification
The flash-done event and the timeout expiry can occur in the same cycle, and the two lead to different flag values. The bench raises `flash_done` on exactly the cycle in which the wait counter reaches its last value. It then expects release with `flash_timeout` still 0, and it also checks the one-cycle-later case. A reset request that arrives during the release filter interval is also provoked, and the bench expects the release count to start again.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
    typedef enum logic [1:0] {
        ST_RESET       = 2'd0,
        ST_WAIT_FLASH  = 2'd1,
        ST_WAIT_CYCLES = 2'd2,
        ST_RUN         = 2'd3
    } seq_state_t;

    localparam int DLY_W   = 3;
    localparam int DLY_MIN = 3;
    localparam int DLY_MAX = 8;

    localparam logic [15:0] PH_EARLY = 16'hFFFF;
    localparam logic [15:0] PH_LATE  = 16'h009B;
endpackage

// File: rtl/rst_seq_filter.sv
module rst_seq_filter #(
    parameter int FILT_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_req,
    output logic released
);
    localparam int CW = $clog2(FILT_CYCLES + 1);
    localparam logic [CW-1:0] CNT_FULL = CW'(FILT_CYCLES);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or posedge rst_req) begin
        if (rst_req) begin
            sync_q <= 2'b00;
            cnt_q  <= '0;
        end else begin
            sync_q <= {sync_q[0], 1'b1};
            if (sync_q[1] && (cnt_q != CNT_FULL)) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign released = (cnt_q == CNT_FULL);
endmodule

// File: rtl/rst_seq_fsm.sv
module rst_seq_fsm
    import rst_seq_pkg::*;
#(
    parameter int FLASH_TIMEOUT = 200000
) (
    input  logic             clk,
    input  logic             rst_req,
    input  logic             released,
    input  logic             boot_int,
    input  logic             flash_done,
    input  logic [DLY_W-1:0] ext_delay,
    output seq_state_t       state,
    output logic             boot_lat,
    output logic             timeout_flag
);
    localparam int CLG  = $clog2(FLASH_TIMEOUT);
    localparam int CNTW = (CLG > 4) ? CLG : 4;
    localparam logic [CNTW-1:0] TO_LAST = CNTW'(FLASH_TIMEOUT - 1);
    localparam int DLY_SPAN = DLY_MAX - DLY_MIN;

    seq_state_t    state_q, state_d;
    logic [CNTW-1:0] cnt_q;
    logic [CNTW-1:0] wc_last;
    logic          to_hit;

    always_comb begin
        if (int'(ext_delay) >= DLY_SPAN) begin
            wc_last = CNTW'(DLY_MAX - 1);
        end else begin
            wc_last = CNTW'(ext_delay) + CNTW'(DLY_MIN - 1);
        end
    end

    assign to_hit = (cnt_q == TO_LAST) && !flash_done;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET: begin
                if (released) begin
                    state_d = boot_int ? ST_WAIT_FLASH : ST_WAIT_CYCLES;
                end
            end
            ST_WAIT_FLASH: begin
                if (flash_done || to_hit) begin
                    state_d = ST_RUN;
                end
            end
            ST_WAIT_CYCLES: begin
                if (cnt_q == wc_last) begin
                    state_d = ST_RUN;
                end
            end
            ST_RUN: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or posedge rst_req) begin
        if (rst_req) begin
            state_q <= ST_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or posedge rst_req) begin
        if (rst_req) begin
            cnt_q        <= '0;
            boot_lat     <= 1'b0;
            timeout_flag <= 1'b0;
        end else begin
            if (state_d != state_q) begin
                cnt_q <= '0;
            end else if (state_q != ST_RUN && state_q != ST_RESET) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (state_q == ST_RESET && released) begin
                boot_lat <= boot_int;
            end
            if (state_q == ST_WAIT_FLASH && to_hit) begin
                timeout_flag <= 1'b1;
            end
        end
    end

    assign state = state_q;
endmodule

// File: rtl/rst_seq_placeholder.sv
module rst_seq_placeholder
    import rst_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_req,
    input  logic        core_running,
    input  logic        rd_req,
    input  logic        rd_fetch,
    input  logic        flash_done,
    input  logic        flash_phase2,
    output logic        ph_valid,
    output logic [15:0] ph_data,
    output logic        illegal_trap
);
    logic answer;

    assign answer = core_running && rd_req && !flash_done;

    always_ff @(posedge clk or posedge rst_req) begin
        if (rst_req) begin
            ph_valid     <= 1'b0;
            ph_data      <= '0;
            illegal_trap <= 1'b0;
        end else begin
            ph_valid     <= answer;
            ph_data      <= answer ? (flash_phase2 ? PH_LATE : PH_EARLY) : 16'h0000;
            illegal_trap <= answer && flash_phase2 && rd_fetch;
        end
    end
endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
    import rst_seq_pkg::*;
#(
    parameter int FILT_CYCLES   = 4,
    parameter int FLASH_TIMEOUT = 200000
) (
    input  logic        clk,
    input  logic        rst_pin_n,
    input  logic        mode_qual_n,
    input  logic        boot_int,
    input  logic [2:0]  ext_delay,
    input  logic        flash_done,
    input  logic        flash_phase2,
    input  logic        rd_req,
    input  logic        rd_fetch,
    output logic        rst_out_n,
    output logic        core_rst,
    output logic        bus_tristate,
    output logic        bus_abort,
    output logic        hold_cancel,
    output logic        port_pullup,
    output logic        flash_timeout,
    output logic        ph_valid,
    output logic [15:0] ph_data,
    output logic        illegal_trap
);
    logic       rst_req;
    logic       released;
    logic       boot_lat;
    seq_state_t state;

    assign rst_req = !rst_pin_n && !mode_qual_n;

    rst_seq_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filter (
        .clk      (clk),
        .rst_req  (rst_req),
        .released (released)
    );

    rst_seq_fsm #(.FLASH_TIMEOUT(FLASH_TIMEOUT)) u_fsm (
        .clk          (clk),
        .rst_req      (rst_req),
        .released     (released),
        .boot_int     (boot_int),
        .flash_done   (flash_done),
        .ext_delay    (ext_delay),
        .state        (state),
        .boot_lat     (boot_lat),
        .timeout_flag (flash_timeout)
    );

    rst_seq_placeholder u_ph (
        .clk          (clk),
        .rst_req      (rst_req),
        .core_running (state == ST_RUN),
        .rd_req       (rd_req),
        .rd_fetch     (rd_fetch),
        .flash_done   (flash_done),
        .flash_phase2 (flash_phase2),
        .ph_valid     (ph_valid),
        .ph_data      (ph_data),
        .illegal_trap (illegal_trap)
    );

    always_comb begin
        rst_out_n    = 1'b1;
        core_rst     = 1'b1;
        bus_tristate = 1'b0;
        bus_abort    = 1'b0;
        hold_cancel  = 1'b0;
        port_pullup  = 1'b0;
        unique case (state)
            ST_RESET: begin
                rst_out_n    = 1'b0;
                bus_tristate = 1'b1;
                bus_abort    = 1'b1;
                hold_cancel  = 1'b1;
                port_pullup  = 1'b1;
            end
            ST_WAIT_FLASH:  core_rst = 1'b1;
            ST_WAIT_CYCLES: core_rst = 1'b1;
            ST_RUN:         core_rst = 1'b0;
        endcase
    end
endmodule

// File: rtl/rst_sequencer_chk.sv
module rst_sequencer_chk (
    input logic        clk,
    input logic        rst_pin_n,
    input logic        mode_qual_n,
    input logic        rst_out_n,
    input logic        core_rst,
    input logic        bus_tristate,
    input logic        port_pullup,
    input logic        flash_timeout,
    input logic        ph_valid,
    input logic [15:0] ph_data,
    input logic        illegal_trap,
    input logic        boot_lat
);
    logic req;
    assign req = !rst_pin_n && !mode_qual_n;

    p_reset_group_r2: assert property (@(posedge clk) disable iff (req)
        !rst_out_n |-> (core_rst && bus_tristate && port_pullup));

    p_release_order_r3: assert property (@(posedge clk) disable iff (req)
        $rose(rst_out_n) |-> core_rst);

    p_ext_min_wait_r7: assert property (@(posedge clk) disable iff (req)
        ($fell(core_rst) && !boot_lat) |-> $past(rst_out_n, 3));

    p_timeout_sticky_r6: assert property (@(posedge clk) disable iff (req)
        flash_timeout |=> flash_timeout);

    p_ph_code_r8: assert property (@(posedge clk) disable iff (req)
        ph_valid |-> ((ph_data == 16'hFFFF) || (ph_data == 16'h009B)));

    p_ph_when_run_r8: assert property (@(posedge clk) disable iff (req)
        ph_valid |-> !core_rst);

    p_trap_late_r9: assert property (@(posedge clk) disable iff (req)
        illegal_trap |-> (ph_valid && ph_data == 16'h009B));
endmodule

bind rst_sequencer rst_sequencer_chk u_chk (
    .clk           (clk),
    .rst_pin_n     (rst_pin_n),
    .mode_qual_n   (mode_qual_n),
    .rst_out_n     (rst_out_n),
    .core_rst      (core_rst),
    .bus_tristate  (bus_tristate),
    .port_pullup   (port_pullup),
    .flash_timeout (flash_timeout),
    .ph_valid      (ph_valid),
    .ph_data       (ph_data),
    .illegal_trap  (illegal_trap),
    .boot_lat      (boot_lat)
);

// File: tb/rst_sequencer_bench.sv
`timescale 1ns/1ps
module rst_sequencer_bench;
    localparam int FILT = 3;
    localparam int TO   = 20;
    localparam int S_RST = 0, S_WF = 1, S_WC = 2, S_RUN = 3;

    logic clk = 1'b0;
    logic rst_pin_n = 1'b0, mode_qual_n = 1'b0, boot_int = 1'b1;
    logic [2:0] ext_delay = 3'd0;
    logic flash_done = 1'b0, flash_phase2 = 1'b0, rd_req = 1'b0, rd_fetch = 1'b0;
    logic rst_out_n, core_rst, bus_tristate, bus_abort, hold_cancel, port_pullup;
    logic flash_timeout, ph_valid, illegal_trap;
    logic [15:0] ph_data;

    int total = 0, bad = 0;
    string tag = "R2";

    always #2.5 clk = ~clk;

    rst_sequencer #(.FILT_CYCLES(FILT), .FLASH_TIMEOUT(TO)) u_rst_sequencer (
        .clk(clk), .rst_pin_n(rst_pin_n), .mode_qual_n(mode_qual_n), .boot_int(boot_int),
        .ext_delay(ext_delay), .flash_done(flash_done), .flash_phase2(flash_phase2),
        .rd_req(rd_req), .rd_fetch(rd_fetch), .rst_out_n(rst_out_n), .core_rst(core_rst),
        .bus_tristate(bus_tristate), .bus_abort(bus_abort), .hold_cancel(hold_cancel),
        .port_pullup(port_pullup), .flash_timeout(flash_timeout), .ph_valid(ph_valid),
        .ph_data(ph_data), .illegal_trap(illegal_trap)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model, advanced and compared after each rising edge
    int m_state = S_RST, m_edges = 0, m_wcnt = 0, m_to = 0;
    int m_pv = 0, m_pd = 0, m_trap = 0;

    always @(posedge clk) begin
        #1;
        if (!rst_pin_n && !mode_qual_n) begin
            m_state = S_RST; m_edges = 0; m_wcnt = 0; m_to = 0;
            m_pv = 0; m_pd = 0; m_trap = 0;
        end else begin
            m_pv   = (m_state == S_RUN && rd_req && !flash_done) ? 1 : 0;
            m_pd   = m_pv ? (flash_phase2 ? 16'h009B : 16'hFFFF) : 0;
            m_trap = (m_pv != 0 && flash_phase2 && rd_fetch) ? 1 : 0;
            case (m_state)
                S_RST: begin
                    m_edges++;
                    if (m_edges == FILT + 3) begin
                        m_state = boot_int ? S_WF : S_WC;
                        m_wcnt = 0;
                    end
                end
                S_WF: begin
                    if (flash_done) m_state = S_RUN;
                    else if (m_wcnt == TO - 1) begin m_state = S_RUN; m_to = 1; end
                    else m_wcnt++;
                end
                S_WC: begin
                    if (m_wcnt == 3 + ((ext_delay > 5) ? 5 : int'(ext_delay)) - 1) m_state = S_RUN;
                    else m_wcnt++;
                end
                default: ;
            endcase
        end
        chk(rst_out_n == (m_state != S_RST), "R2", rst_out_n, m_state != S_RST);
        chk({bus_tristate, bus_abort, hold_cancel, port_pullup} == ((m_state == S_RST) ? 4'hF : 4'h0),
            "R2", {bus_tristate, bus_abort, hold_cancel, port_pullup}, (m_state == S_RST) ? 15 : 0);
        chk(core_rst == (m_state != S_RUN), tag, core_rst, m_state != S_RUN);
        chk(flash_timeout == m_to[0], "R6", flash_timeout, m_to);
        chk(ph_valid == m_pv[0] && ph_data == m_pd[15:0], "R8", {ph_valid, ph_data}, {m_pv[0], m_pd[15:0]});
        chk(illegal_trap == m_trap[0], "R9", illegal_trap, m_trap);
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hit_reset();
        rst_pin_n = 1'b0; mode_qual_n = 1'b0;
        tick(2);
    endtask

    task automatic ext_boot(input logic [2:0] d, input int exp);
        int n = 0;
        tag = "R7";
        boot_int = 1'b0; ext_delay = d;
        hit_reset();
        rst_pin_n = 1'b1;
        tick(FILT + 3);
        boot_int = 1'b1; // R4: must not matter after capture
        while (core_rst && n < 20) begin tick(1); n++; end
        chk(n == exp, "R7", n, exp);
        boot_int = 1'b0;
    endtask

    initial begin : watchdog
        #(5ns * 20000);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(4);
        chk(!rst_out_n && core_rst && bus_tristate && port_pullup, "R2", rst_out_n, 0);

        // internal boot with flash done
        tag = "R5";
        rst_pin_n = 1'b1;
        tick(FILT + 2);
        chk(rst_out_n == 1'b0, "R3", rst_out_n, 0);
        tick(1);
        chk(rst_out_n == 1'b1 && core_rst, "R4", {rst_out_n, core_rst}, 3);
        tick(5);
        flash_done = 1'b1;
        tick(1);
        chk(core_rst == 1'b0, "R5", core_rst, 0);

        // async entry from run, glitch during filter, external boot
        tag = "R10";
        flash_done = 1'b0; boot_int = 1'b0; ext_delay = 3'd0;
        rst_pin_n = 1'b0;
        #1;
        chk(rst_out_n == 1'b0 && core_rst, "R1", rst_out_n, 0);
        tick(3);
        tag = "R3";
        rst_pin_n = 1'b1; tick(2);
        rst_pin_n = 1'b0; tick(1);
        rst_pin_n = 1'b1;
        tick(FILT + 2);
        chk(rst_out_n == 1'b0, "R3", rst_out_n, 0);
        tick(1);
        chk(rst_out_n == 1'b1, "R3", rst_out_n, 1);
        tag = "R7";
        tick(2);
        chk(core_rst == 1'b1, "R7", core_rst, 1);
        tick(1);
        chk(core_rst == 1'b0, "R7", core_rst, 0);

        // placeholder reads
        rd_req = 1'b1; flash_phase2 = 1'b0;
        tick(1);
        chk(ph_valid && ph_data == 16'hFFFF, "R8", ph_data, 16'hFFFF);
        flash_phase2 = 1'b1; rd_fetch = 1'b1;
        tick(1);
        chk(ph_valid && ph_data == 16'h009B && illegal_trap, "R9", ph_data, 16'h009B);
        rd_fetch = 1'b0;
        tick(1);
        chk(!illegal_trap, "R9", illegal_trap, 0);
        flash_done = 1'b1;
        tick(2);
        chk(!ph_valid && ph_data == 16'h0, "R8", ph_data, 0);
        rd_req = 1'b0; flash_phase2 = 1'b0;

        // qualifier high: reset pin ignored
        tag = "R1";
        mode_qual_n = 1'b1; rst_pin_n = 1'b0;
        tick(4);
        chk(rst_out_n && !core_rst && !bus_tristate, "R1", {rst_out_n, core_rst}, 2);
        rst_pin_n = 1'b1; mode_qual_n = 1'b0;

        // delay settings
        ext_boot(3'd7, 8);
        ext_boot(3'd5, 8);
        ext_boot(3'd2, 5);
        chk(!core_rst, "R4", core_rst, 0);

        // flash timeout
        tag = "R6";
        flash_done = 1'b0; boot_int = 1'b1;
        hit_reset();
        rst_pin_n = 1'b1;
        tick(FILT + 3);
        begin
            int n = 0;
            while (core_rst && n < TO + 5) begin tick(1); n++; end
            chk(n == TO && flash_timeout, "R6", n, TO);
        end
        rd_req = 1'b1;
        tick(1);
        chk(ph_data == 16'hFFFF, "R8", ph_data, 16'hFFFF);
        rd_req = 1'b0; flash_done = 1'b1;
        tick(2);
        chk(flash_timeout == 1'b1, "R6", flash_timeout, 1);
        hit_reset();
        chk(flash_timeout == 1'b0, "R6", flash_timeout, 0);

        // done in the same cycle as expiry: no flag
        flash_done = 1'b0;
        rst_pin_n = 1'b1;
        tick(FILT + 3);
        tick(TO - 1);
        flash_done = 1'b1;
        tick(1);
        chk(!core_rst && !flash_timeout, "R6", {core_rst, flash_timeout}, 0);

        // done one cycle late: flag set
        flash_done = 1'b0;
        hit_reset();
        rst_pin_n = 1'b1;
        tick(FILT + 3);
        tick(TO);
        flash_done = 1'b1;
        tick(1);
        chk(!core_rst && flash_timeout, "R6", {core_rst, flash_timeout}, 1);

        // reset from the waiting states
        tag = "R10";
        flash_done = 1'b0;
        hit_reset();
        rst_pin_n = 1'b1;
        tick(FILT + 5);
        rst_pin_n = 1'b0;
        #1;
        chk(!rst_out_n && bus_abort && hold_cancel, "R10", rst_out_n, 0);
        boot_int = 1'b0;
        tick(2);
        rst_pin_n = 1'b1;
        tick(FILT + 4);
        rst_pin_n = 1'b0;
        #1;
        chk(!rst_out_n && core_rst, "R10", rst_out_n, 0);
        tick(2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule